// File: doc/BRIEF.md
# AC-link output frame serializer

This block is the controller-side transmitter of an AC-link. It runs on the serial bit clock and sends one frame every 256 bit clocks. Each frame is a 16-bit tag slot followed by twelve 20-bit data slots. The block also drives the frame-marker line `sync`. Its inputs are a pending command (address, read/write flag, 16-bit write data), a left/right playback pair with a programmable resolution, and four surround samples. Each slot goes out most significant bit first.

All inputs are sampled once, on the bit-clock edge that starts a frame. Input changes after that edge only affect the next frame. The block zero-stuffs unused positions in three cases:
- the write-data slot carries no data when the command is a read;
- playback samples narrower than 20 bits have their trailing bits cleared;
- unsupported slots are always sent as zeros.

The control is a three-state machine:
- **ST_IDLE** is held during reset.
- **ST_TAG** covers the 16 tag bits.
- **ST_DATA** covers the 240 data bits.

Its transitions are:
- **go_first**: ST_IDLE to ST_TAG, on the first edge after reset.
- **tag_done**: ST_TAG to ST_DATA, after tag bit 15.
- **frame_wrap**: ST_DATA to ST_TAG, after frame bit 255.

Top module: `acl_frame_tx`

## Requirements
- R1: While `rst_n` is low, `sync` and `sdata_out` are both 0.
- R2: After reset, `sync` is high for exactly 16 consecutive bit clocks and then low for exactly 240, repeating every 256 clocks.
- R3: The first tag bit appears on `sdata_out` at the same clock edge where `sync` goes high. The first frame starts on the first edge after reset is released. Each slot is sent from its bit 19 down to bit 0, and slots are sent in the order 1 to 12.
- R4: Tag bit 15 (sent first) is the OR of all slot tags. Tag bit 15-n is the valid flag of slot n, for n = 1..12. Tag bits 2:0 are 0.
- R5: With `cmd_valid`=1, slot 1 carries `cmd_read` in bit 19 (1 = read) and `cmd_addr` in bits 18:12, with bits 11:0 at 0, and its tag is 1. With `cmd_valid`=0, slot 1 and the tags of slots 1 and 2 are 0.
- R6: For a valid write (`cmd_read`=0), slot 2 carries `cmd_wdata` in bits 19:4, bits 3:0 are 0, and the slot 2 tag is 1.
- R7: For a valid read, or with no command pending, all 20 bits of slot 2 and its tag are 0.
- R8: Slots 3 and 4 carry `pcm_left` and `pcm_right`, MSB-justified. With resolution r = `pcm_res` (values 0 or above 20 mean 20), bits 19-r..0 are forced to 0. Their tags equal `pcm_valid`, and their data is 0 when `pcm_valid`=0.
- R9: Slots 5, 10, 11 and 12 are always all zeros, with their tags 0.
- R10: Slot 6+i (i = 0..3) carries `sur_data[20*i+19:20*i]` with tag `sur_valid[i]`, and is 0 when that tag is 0.
- R11: Inputs are captured at the frame-start edge only. A change made during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is pending for this frame |
| cmd_read | input | 1 | 1 = read command, 0 = write |
| cmd_addr | input | 7 | Command register address |
| cmd_wdata | input | 16 | Command write data |
| pcm_valid | input | 1 | Playback pair present |
| pcm_res | input | 5 | Playback sample resolution in bits |
| pcm_left | input | 20 | Left playback sample, MSB-justified |
| pcm_right | input | 20 | Right playback sample, MSB-justified |
| sur_valid | input | 4 | Per-slot valid for surround slots 6..9 |
| sur_data | input | 80 | Surround samples, slot 6 in bits 19:0 |
| sync | output | 1 | Frame marker, high during the tag phase |
| sdata_out | output | 1 | Serial frame data |

## Verification
The bench builds the block with its default geometry: 16-bit tag, twelve 20-bit slots, 7-bit address and 16-bit command data. With these values a full 256-clock frame fits in a few hundred cycles, so several complete frames run back to back. The bench steps through a write command, a read command, no command, and the resolutions 16, 20, 8 and the out-of-range value 0. One frame also has its inputs changed halfway through, which exercises the capture-at-frame-start rule.

// File: rtl/acl_pkg.sv
package acl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2
    } acl_state_e;

    // Number of trailing positions cleared for a sample of the given resolution.
    function automatic int unsigned pad_bits(input int unsigned res, input int unsigned width);
        int unsigned eff;
        eff = (res == 0 || res > width) ? width : res;
        return width - eff;
    endfunction
endpackage

// File: rtl/acl_slot_fmt.sv
module acl_slot_fmt #(
    parameter int SLOT_W = 20,
    parameter int RES_W  = 5
) (
    input  logic              valid,
    input  logic [RES_W-1:0]  res,
    input  logic [SLOT_W-1:0] sample,
    output logic [SLOT_W-1:0] slot
);
    import acl_pkg::*;

    int unsigned pad;

    always_comb begin
        pad  = pad_bits(int'(res), SLOT_W);
        slot = '0;
        if (valid) begin
            for (int b = 0; b < SLOT_W; b++) begin
                slot[b] = (b < int'(pad)) ? 1'b0 : sample[b];
            end
        end
    end
endmodule

// File: rtl/acl_frame_build.sv
module acl_frame_build #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int NSLOT  = 12,
    parameter int ADDR_W = 7,
    parameter int CMD_W  = 16,
    parameter int RES_W  = 5,
    parameter int SUR_N  = 4,
    localparam int FRAME_W = TAG_W + NSLOT * SLOT_W
) (
    input  logic                    cmd_valid,
    input  logic                    cmd_read,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [CMD_W-1:0]        cmd_wdata,
    input  logic                    pcm_valid,
    input  logic [RES_W-1:0]        pcm_res,
    input  logic [SLOT_W-1:0]       pcm_left,
    input  logic [SLOT_W-1:0]       pcm_right,
    input  logic [SUR_N-1:0]        sur_valid,
    input  logic [SUR_N*SLOT_W-1:0] sur_data,
    output logic [FRAME_W-1:0]      frame
);
    localparam int SUR_BASE = 6;
    localparam int TAG_PAD  = TAG_W - 1 - NSLOT;

    logic [SLOT_W-1:0] slot_w [1:NSLOT];
    logic [NSLOT:1]    tag_v;

    // Command address slot and command data slot.
    always_comb begin
        slot_w[1] = '0;
        slot_w[2] = '0;
        tag_v[1]  = cmd_valid;
        tag_v[2]  = cmd_valid && !cmd_read;
        if (cmd_valid) begin
            slot_w[1][SLOT_W-1]          = cmd_read;
            slot_w[1][SLOT_W-2 -: ADDR_W] = cmd_addr;
            if (!cmd_read) begin
                slot_w[2][SLOT_W-1 -: CMD_W] = cmd_wdata;
            end
        end
    end

    // Playback pair with resolution masking.
    acl_slot_fmt #(.SLOT_W(SLOT_W), .RES_W(RES_W)) u_fmt_left (
        .valid  (pcm_valid),
        .res    (pcm_res),
        .sample (pcm_left),
        .slot   (slot_w[3])
    );
    acl_slot_fmt #(.SLOT_W(SLOT_W), .RES_W(RES_W)) u_fmt_right (
        .valid  (pcm_valid),
        .res    (pcm_res),
        .sample (pcm_right),
        .slot   (slot_w[4])
    );
    assign tag_v[3] = pcm_valid;
    assign tag_v[4] = pcm_valid;

    // Unsupported slot between playback and surround.
    assign slot_w[5] = '0;
    assign tag_v[5]  = 1'b0;

    // Surround slots, full resolution.
    generate
        for (genvar i = 0; i < SUR_N; i++) begin : g_sur
            assign slot_w[SUR_BASE+i] = sur_valid[i] ? sur_data[i*SLOT_W +: SLOT_W] : '0;
            assign tag_v[SUR_BASE+i]  = sur_valid[i];
        end
        for (genvar k = SUR_BASE + SUR_N; k <= NSLOT; k++) begin : g_zero
            assign slot_w[k] = '0;
            assign tag_v[k]  = 1'b0;
        end
    endgenerate

    // Frame assembly: tag slot first, then slots 1..NSLOT.
    assign frame[FRAME_W-1] = |tag_v;
    generate
        for (genvar n = 1; n <= NSLOT; n++) begin : g_asm
            assign frame[FRAME_W-1-n] = tag_v[n];
            assign frame[FRAME_W-TAG_W-1-(n-1)*SLOT_W -: SLOT_W] = slot_w[n];
        end
        if (TAG_PAD > 0) begin : g_tag_pad
            assign frame[FRAME_W-TAG_W +: TAG_PAD] = '0;
        end
    endgenerate
endmodule

// File: rtl/acl_frame_tx.sv
module acl_frame_tx #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int NSLOT  = 12,
    parameter int ADDR_W = 7,
    parameter int CMD_W  = 16,
    parameter int RES_W  = 5,
    parameter int SUR_N  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic                    cmd_read,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [CMD_W-1:0]        cmd_wdata,
    input  logic                    pcm_valid,
    input  logic [RES_W-1:0]        pcm_res,
    input  logic [SLOT_W-1:0]       pcm_left,
    input  logic [SLOT_W-1:0]       pcm_right,
    input  logic [SUR_N-1:0]        sur_valid,
    input  logic [SUR_N*SLOT_W-1:0] sur_data,
    output logic                    sync,
    output logic                    sdata_out
);
    import acl_pkg::*;

    localparam int FRAME_W = TAG_W + NSLOT * SLOT_W;
    localparam int POS_W   = $clog2(FRAME_W);
    localparam logic [POS_W-1:0] POS_TAG_END   = POS_W'(TAG_W - 1);
    localparam logic [POS_W-1:0] POS_FRAME_END = POS_W'(FRAME_W - 1);

    acl_state_e         state_q, state_d;
    logic [POS_W-1:0]   pos_q;
    logic [FRAME_W-1:0] frame_w;
    logic [FRAME_W-1:0] shreg_q;
    logic               frame_wrap;

    acl_frame_build #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT), .ADDR_W(ADDR_W),
        .CMD_W(CMD_W), .RES_W(RES_W), .SUR_N(SUR_N)
    ) u_build (
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .pcm_valid (pcm_valid),
        .pcm_res   (pcm_res),
        .pcm_left  (pcm_left),
        .pcm_right (pcm_right),
        .sur_valid (sur_valid),
        .sur_data  (sur_data),
        .frame     (frame_w)
    );

    // Next-state logic.
    always_comb begin
        state_d    = state_q;
        frame_wrap = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d    = ST_TAG;
                frame_wrap = 1'b1;
            end
            ST_TAG: begin
                if (pos_q == POS_TAG_END) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (pos_q == POS_FRAME_END) begin
                    state_d    = ST_TAG;
                    frame_wrap = 1'b1;
                end
            end
            default: begin
                state_d    = ST_IDLE;
            end
        endcase
    end

    // State register and bit position.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= frame_wrap ? '0 : pos_q + 1'b1;
        end
    end

    // Outputs: frame capture and shifting.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            sdata_out <= 1'b0;
            sync      <= 1'b0;
        end else begin
            sync <= (state_d == ST_TAG);
            if (frame_wrap) begin
                sdata_out <= frame_w[FRAME_W-1];
                shreg_q   <= {frame_w[FRAME_W-2:0], 1'b0};
            end else begin
                sdata_out <= shreg_q[FRAME_W-1];
                shreg_q   <= {shreg_q[FRAME_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/acl_frame_tx_chk.sv
module acl_frame_tx_chk #(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int NSLOT   = 12,
    parameter int RES_W   = 5,
    localparam int FRAME_W = TAG_W + NSLOT * SLOT_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync,
    input logic               cmd_valid,
    input logic               cmd_read,
    input logic [RES_W-1:0]   pcm_res,
    input logic               pcm_valid,
    input logic [FRAME_W-1:0] frame_w
);
    localparam int S2_TOP = FRAME_W - TAG_W - SLOT_W - 1;
    localparam int S3_TOP = FRAME_W - TAG_W - 2 * SLOT_W - 1;

    int unsigned hi_run, lo_run;
    logic        seen_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run  <= 0;
            lo_run  <= 0;
            seen_hi <= 1'b0;
        end else begin
            hi_run  <= sync ? hi_run + 1 : 0;
            lo_run  <= sync ? 0 : lo_run + 1;
            if (sync) seen_hi <= 1'b1;
        end
    end

    p_sync_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync) |-> hi_run == TAG_W);

    p_sync_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync) && seen_hi) |-> lo_run == FRAME_W - TAG_W);

    p_read_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_read) |-> (frame_w[S2_TOP -: SLOT_W] == '0 && !frame_w[FRAME_W-3]));

    p_pcm_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_valid && pcm_res == RES_W'(16)) |-> frame_w[S3_TOP-16 -: 4] == 4'b0);

    p_frame_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_w[FRAME_W-1] == (frame_w[FRAME_W-2 -: NSLOT] != '0));
endmodule

bind acl_frame_tx acl_frame_tx_chk #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT), .RES_W(RES_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync      (sync),
    .cmd_valid (cmd_valid),
    .cmd_read  (cmd_read),
    .pcm_res   (pcm_res),
    .pcm_valid (pcm_valid),
    .frame_w   (frame_w)
);

// File: tb/acl_frame_tx_tb.sv
module acl_frame_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 0, cmd_read = 0;
    logic [6:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        pcm_valid = 0;
    logic [4:0]  pcm_res = 5'd20;
    logic [19:0] pcm_left = '0, pcm_right = '0;
    logic [3:0]  sur_valid = '0;
    logic [79:0] sur_data = '0;
    logic        sync, sdata_out;

    int total = 0, bad = 0;

    always #2 clk = ~clk;

    acl_frame_tx u_dut (.*);

    // Reference model state
    bit eq[$];
    bit sq[$];
    bit exp_b, exp_s, model_on = 0;
    logic        s_cv, s_rd;
    logic [6:0]  s_addr;
    logic [15:0] s_wd;
    logic        s_pv;
    logic [4:0]  s_res;
    logic [19:0] s_l, s_r;
    logic [3:0]  s_sv;
    logic [79:0] s_sd;

    function automatic logic [19:0] masked(input logic [19:0] v, input int res);
        int eff;
        logic [19:0] o;
        eff = (res == 0 || res > 20) ? 20 : res;
        o = v;
        for (int b = 0; b < 20; b++) if (b < 20 - eff) o[b] = 1'b0;
        return o;
    endfunction

    function automatic logic [19:0] exp_slot(input int n);
        logic [19:0] w;
        w = '0;
        if (n == 1 && s_cv) w = {s_rd, s_addr, 12'h000};
        if (n == 2 && s_cv && !s_rd) w = {s_wd, 4'h0};
        if (n == 3 && s_pv) w = masked(s_l, int'(s_res));
        if (n == 4 && s_pv) w = masked(s_r, int'(s_res));
        if (n >= 6 && n <= 9 && s_sv[n-6]) w = s_sd[(n-6)*20 +: 20];
        return w;
    endfunction

    function automatic bit exp_tag(input int n);
        case (n)
            1: return s_cv;
            2: return s_cv && !s_rd;
            3, 4: return s_pv;
            6, 7, 8, 9: return s_sv[n-6];
            default: return 1'b0;
        endcase
    endfunction

    task automatic build_frame();
        bit fv;
        logic [19:0] w;
        s_cv = cmd_valid; s_rd = cmd_read; s_addr = cmd_addr; s_wd = cmd_wdata;
        s_pv = pcm_valid; s_res = pcm_res; s_l = pcm_left; s_r = pcm_right;
        s_sv = sur_valid; s_sd = sur_data;
        fv = 0;
        for (int n = 1; n <= 12; n++) fv |= exp_tag(n);
        eq.push_back(fv);
        for (int n = 1; n <= 12; n++) eq.push_back(exp_tag(n));
        for (int k = 0; k < 3; k++) eq.push_back(1'b0);
        for (int n = 1; n <= 12; n++) begin
            w = exp_slot(n);
            for (int b = 19; b >= 0; b--) eq.push_back(w[b]);
        end
        for (int k = 0; k < 256; k++) sq.push_back(k < 16);
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            if (eq.size() == 0) build_frame();
            exp_b = eq.pop_front();
            exp_s = sq.pop_front();
            model_on = 1;
        end
    end

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Cycle compare and frame capture
    bit cap[256];
    int idx = -1;
    logic prev_sync = 0;
    int frames_seen = 0;

    function automatic logic [19:0] cap_slot(input int n);
        logic [19:0] w;
        for (int b = 0; b < 20; b++) w[b] = cap[16 + (n-1)*20 + (19-b)];
        return w;
    endfunction

    task automatic analyse();
        logic [15:0] tag;
        for (int i = 0; i < 16; i++) tag[15-i] = cap[i];
        check("R4 tag slot", 80'(tag), 80'({|{s_cv, s_pv, s_sv}, s_cv, s_cv && !s_rd, s_pv, s_pv,
              1'b0, s_sv[0], s_sv[1], s_sv[2], s_sv[3], 3'b000, 3'b000}));
        check("R5 slot1", 80'(cap_slot(1)), s_cv ? 80'({s_rd, s_addr, 12'h0}) : 80'(0));
        if (s_cv && !s_rd) check("R6 write slot2", 80'(cap_slot(2)), 80'({s_wd, 4'h0}));
        else               check("R7 blank slot2", 80'(cap_slot(2)), 80'(0));
        if (s_pv && s_res == 5'd16) check("R8 16-bit low nibble", 80'(cap_slot(3) & 20'hF), 80'(0));
        check("R8 left", 80'(cap_slot(3)), s_pv ? 80'(masked(s_l, int'(s_res))) : 80'(0));
        check("R8 right", 80'(cap_slot(4)), s_pv ? 80'(masked(s_r, int'(s_res))) : 80'(0));
        check("R9 unused slots", 80'({cap_slot(5), cap_slot(10), cap_slot(11), cap_slot(12)}), 80'(0));
        for (int i = 0; i < 4; i++)
            check("R10 surround", 80'(cap_slot(6+i)), s_sv[i] ? 80'(s_sd[i*20 +: 20]) : 80'(0));
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            check("R1 reset outputs", 80'({sync, sdata_out}), 80'(0));
        end else if (model_on) begin
            check("R2 sync", 80'(sync), 80'(exp_s));
            check("R3 serial bit", 80'(sdata_out), 80'(exp_b));
            if (sync && !prev_sync) idx = 0;
            if (idx >= 0) begin
                cap[idx] = sdata_out;
                idx++;
                if (idx == 256) begin
                    analyse();
                    frames_seen++;
                    idx = -1;
                end
            end
        end
        prev_sync = sync;
    end

    task automatic wait_boundary();
        do @(negedge clk); while (!(model_on && eq.size() == 0));
    endtask

    logic [19:0] keep_left;

    initial begin
        cmd_valid = 1; cmd_read = 0; cmd_addr = 7'h2C; cmd_wdata = 16'hBEEF;
        pcm_valid = 1; pcm_res = 5'd16; pcm_left = 20'hABCDF; pcm_right = 20'h1234F;
        sur_valid = 4'b1010;
        sur_data = {20'h11111, 20'h22222, 20'h33333, 20'h44444};
        repeat (4) @(negedge clk);
        rst_n = 1;
        // Frame 1 (write, 16-bit) already latched; then a read frame at 20 bits.
        wait_boundary();
        cmd_read = 1; cmd_addr = 7'h7E; cmd_wdata = 16'hFFFF; pcm_res = 5'd20;
        sur_valid = 4'b0101;
        // Mid-frame change must not alter this frame (R11)
        repeat (100) @(negedge clk);
        keep_left = s_l;
        pcm_left = 20'h0F0F0; cmd_read = 0;
        wait_boundary();
        check("R11 latched sample", 80'(cap_slot(3)), 80'(masked(keep_left, 20)));
        check("R11 latched read", 80'(cap_slot(2)), 80'(0));
        cmd_valid = 0; pcm_res = 5'd8; pcm_right = 20'hFFFFF; sur_valid = 4'b1111;
        wait_boundary();
        pcm_valid = 0; pcm_res = 5'd0; sur_valid = 4'b0000;
        wait_boundary();
        cmd_valid = 1; cmd_read = 0; cmd_wdata = 16'h0001; pcm_valid = 1; pcm_res = 5'd0;
        wait_boundary();
        wait_boundary();
        repeat (2) @(negedge clk);
        check("R2 frames completed", 80'(frames_seen >= 5), 80'(1));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule